// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block collects a bank of level-driven hardware interrupt inputs and a bank of software-raised interrupt sources, and steers each one to one of a handful of CPU interrupt outputs. Every source has its own 64-bit routing word. The word holds an enable, a target-thread tag that is stored and read back, and a 4-bit output selector. A CPU output is high while any enabled source that selects it has its pending bit set.

Software sources start at index 64. Software raises and lowers them by writing bit masks to a write-one-to-set region and a write-one-to-clear region. One processor can therefore signal another through the same routing path as a device interrupt. Hardware sources take their pending bits straight from their input pins, through a two-flop synchronizer. All state is reached through a plain word-addressed register port with a registered read.

The address is `{region[1:0], index[IDX_W-1:0]}`, with `IDX_W = clog2(64 + SW_SRCS)`. The regions are: 0 routing words, with index equal to the source number; 1 pending read; 2 set; 3 clear. In regions 1 to 3 the index is a pending-word number, and word w covers sources 64w to 64w+63.

Top module: `pic_router`

## Requirements
- R1: After reset every routing word reads zero, every software pending bit is zero, and `irq_o` is zero.
- R2: A write to routing word s (region 0, index s) keeps bit 31 as enable, bits 30:8 as target thread and bits 3:0 as output selector. All other bits read back as zero.
- R3: `rd_data_o` takes the addressed value on the clock edge that samples `rd_en_i` high. It holds that value, whatever the block's state does, until the next read.
- R4: A write of mask M to the set region at software word w sets the pending bit of source 64w+i for every 1 bit i of M. Bits that are 0 in M leave their pending bits unchanged.
- R5: A write of mask M to the clear region at software word w clears the pending bits under the 1 bits of M and leaves the rest unchanged. An all-zero mask changes nothing.
- R6: A hardware source's pending bit equals its input delayed by two clocks, so `irq_o` follows an input change on the third edge. Set and clear writes to word 0 do not change hardware pending bits.
- R7: `irq_o[j]` is registered. It is high one clock after some enabled source with selector j is pending, and it stays high while any such source remains pending (OR of all such sources).
- R8: A source whose selector is `NUM_OUT` or above drives no output, even when it is enabled and pending.
- R9: A disabled source (enable bit 0, including an all-zero routing word) drives no output, but its pending bit stays visible in the pending read region.
- R10: Reading pending word w returns the pending bit of source 64w+i in bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq_i | input | HW_SRCS | Hardware interrupt levels, asynchronous |
| addr_i | input | IDX_W+2 | Word address: region in top two bits, index below |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 64 | Read data, valid the cycle after the read |
| irq_o | output | NUM_OUT | CPU interrupt outputs |

## Verification
The bench builds the block with its defaults: 64 hardware sources, 64 software sources and six outputs. This gives one hardware pending word at index 0 and one software word at index 1. With these values the bench can drive set and clear writes at the hardware word and confirm they are ignored. It can also try selector values 6 and 15, which fall past the last output, and put two sources on one line to show the OR. It also covers two sources on separate lines and the exact three-edge delay from a hardware pin to an output.

// File: rtl/pic_pkg.sv
// Shared constants, types and helpers for the interrupt routing controller.
// Assumes 64-bit register words and software sources starting at index 64.
package pic_pkg;
    localparam int SW_BASE   = 64;
    localparam int WORD_BITS = 64;
    localparam int SEL_W     = 4;
    localparam int TID_W     = 23;
    localparam int EN_POS    = 31;
    localparam int TID_POS   = 8;

    // Stored part of one routing word
    typedef struct packed {
        logic             en;
        logic [TID_W-1:0] tid;
        logic [SEL_W-1:0] sel;
    } pic_cfg_t;

    // Register regions selected by the two top address bits
    typedef enum logic [1:0] {
        RGN_CFG  = 2'd0,
        RGN_PEND = 2'd1,
        RGN_SET  = 2'd2,
        RGN_CLR  = 2'd3
    } pic_region_e;

    // Build the 64-bit read view of a routing word; reserved bits are zero
    function automatic logic [WORD_BITS-1:0] cfg_to_word(input pic_cfg_t c);
        logic [WORD_BITS-1:0] w;
        w = '0;
        w[EN_POS]              = c.en;
        w[TID_POS +: TID_W]    = c.tid;
        w[SEL_W-1:0]           = c.sel;
        return w;
    endfunction
endpackage

// File: rtl/pic_sync2.sv
// Two-flop synchronizer for the hardware interrupt levels.
// Assumes each bit is an independent level; no glitch filtering.
module pic_sync2 #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    // Shift the asynchronous levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_o    <= '0;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/pic_soft_pend.sv
// Pending bits of the software sources, raised and lowered by mask writes.
// Assumes set and clear never arrive in the same cycle (distinct regions).
module pic_soft_pend #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    // Apply the clear mask then the set mask; zero mask bits keep state
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/pic_src_cfg.sv
// One source slot: holds the routing word and turns the pending bit into
// a one-hot request on the selected output, if enabled and in range.
// Assumes NUM_OUT <= 16 so every output is reachable by the 4-bit selector.
module pic_src_cfg
    import pic_pkg::*;
#(
    parameter int NUM_OUT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  pic_cfg_t           wdata_i,
    input  logic               pend_i,
    output pic_cfg_t           cfg_o,
    output logic [NUM_OUT-1:0] route_o
);
    // Store the routing word on a write addressed to this slot
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_o <= '0;
        else if (we_i) cfg_o <= wdata_i;
    end

    // Request the selected line; selectors past the last line match nothing
    always_comb begin
        for (int j = 0; j < NUM_OUT; j++) begin
            route_o[j] = pend_i && cfg_o.en && (cfg_o.sel == SEL_W'(j));
        end
    end
endmodule

// File: rtl/pic_regif.sv
// Register port decode: routing-word writes, set/clear masks for the
// software words, and a registered read mux over routing and pending state.
// Assumes address = {region, index} and one access type per region.
module pic_regif
    import pic_pkg::*;
#(
    parameter int NSRC    = 128,
    parameter int SW_SRCS = 64,
    parameter int IDX_W   = 7,
    parameter int NWORDS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W+1:0]     addr_i,
    input  logic                 wr_en_i,
    input  logic [WORD_BITS-1:0] wr_data_i,
    input  logic                 rd_en_i,
    input  pic_cfg_t [NSRC-1:0]  cfg_all_i,
    input  logic [NSRC-1:0]      pend_all_i,
    output logic [NSRC-1:0]      cfg_we_o,
    output pic_cfg_t             cfg_wdata_o,
    output logic [SW_SRCS-1:0]   sw_set_o,
    output logic [SW_SRCS-1:0]   sw_clr_o,
    output logic [WORD_BITS-1:0] rd_data_o
);
    localparam int SW_WORD0 = SW_BASE / WORD_BITS;
    localparam int SW_WORDS = SW_SRCS / WORD_BITS;

    pic_region_e          region;
    logic [IDX_W-1:0]     idx;
    logic [WORD_BITS-1:0] rd_next;

    assign region = pic_region_e'(addr_i[IDX_W+1:IDX_W]);
    assign idx    = addr_i[IDX_W-1:0];

    // Split the write data into the stored routing fields
    always_comb begin
        cfg_wdata_o.en  = wr_data_i[EN_POS];
        cfg_wdata_o.tid = wr_data_i[TID_POS +: TID_W];
        cfg_wdata_o.sel = wr_data_i[SEL_W-1:0];
    end

    // One write strobe per routing slot
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            cfg_we_o[s] = wr_en_i && (region == RGN_CFG) && (idx == IDX_W'(s));
        end
    end

    // Route set/clear masks only to software pending words
    always_comb begin
        for (int w = 0; w < SW_WORDS; w++) begin
            sw_set_o[w*WORD_BITS +: WORD_BITS] =
                (wr_en_i && region == RGN_SET && idx == IDX_W'(SW_WORD0 + w)) ? wr_data_i : '0;
            sw_clr_o[w*WORD_BITS +: WORD_BITS] =
                (wr_en_i && region == RGN_CLR && idx == IDX_W'(SW_WORD0 + w)) ? wr_data_i : '0;
        end
    end

    // Select the read value; unmapped addresses return zero
    always_comb begin
        rd_next = '0;
        case (region)
            RGN_CFG: begin
                for (int s = 0; s < NSRC; s++) begin
                    if (idx == IDX_W'(s)) rd_next = cfg_to_word(cfg_all_i[s]);
                end
            end
            RGN_PEND: begin
                for (int w = 0; w < NWORDS; w++) begin
                    if (idx == IDX_W'(w)) rd_next = pend_all_i[w*WORD_BITS +: WORD_BITS];
                end
            end
            default: rd_next = '0;
        endcase
    end

    // Register the read result and hold it between reads
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_next;
    end
endmodule

// File: rtl/pic_router.sv
// Top of the interrupt routing controller: synchronizes hardware levels,
// keeps software pending bits, holds one routing word per source and ORs
// the requests into registered CPU interrupt outputs.
// Assumes HW_SRCS is 64 (or 0) and SW_SRCS a nonzero multiple of 64.
module pic_router
    import pic_pkg::*;
#(
    parameter int HW_SRCS = 64,
    parameter int SW_SRCS = 64,
    parameter int NUM_OUT = 6,
    localparam int NSRC   = SW_BASE + SW_SRCS,
    localparam int NWORDS = NSRC / WORD_BITS,
    localparam int IDX_W  = $clog2(NSRC),
    localparam int ADDR_W = IDX_W + 2,
    localparam int HW_W   = (HW_SRCS > 0) ? HW_SRCS : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HW_W-1:0]      hw_irq_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [WORD_BITS-1:0] wr_data_i,
    input  logic                 rd_en_i,
    output logic [WORD_BITS-1:0] rd_data_o,
    output logic [NUM_OUT-1:0]   irq_o
);
    logic [HW_W-1:0]      hw_sync;
    logic [SW_SRCS-1:0]   sw_set;
    logic [SW_SRCS-1:0]   sw_clr;
    logic [SW_SRCS-1:0]   sw_pend;
    logic [NSRC-1:0]      pend_all;
    logic [NSRC-1:0]      cfg_we;
    pic_cfg_t             cfg_wdata;
    pic_cfg_t [NSRC-1:0]  cfg_all;
    logic [NUM_OUT-1:0]   route [NSRC];
    logic [NUM_OUT-1:0]   line_any;

    pic_sync2 #(.W(HW_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hw_irq_i),
        .q_o   (hw_sync)
    );

    pic_soft_pend #(.N(SW_SRCS)) u_soft (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sw_set),
        .clr_i  (sw_clr),
        .pend_o (sw_pend)
    );

    pic_regif #(
        .NSRC    (NSRC),
        .SW_SRCS (SW_SRCS),
        .IDX_W   (IDX_W),
        .NWORDS  (NWORDS)
    ) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .rd_en_i     (rd_en_i),
        .cfg_all_i   (cfg_all),
        .pend_all_i  (pend_all),
        .cfg_we_o    (cfg_we),
        .cfg_wdata_o (cfg_wdata),
        .sw_set_o    (sw_set),
        .sw_clr_o    (sw_clr),
        .rd_data_o   (rd_data_o)
    );

    // Per-source pending bit and routing slot; the gap between the two banks is empty
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        if (s < HW_SRCS) begin : g_hw
            assign pend_all[s] = hw_sync[s];
        end else if (s >= SW_BASE) begin : g_sw
            assign pend_all[s] = sw_pend[s - SW_BASE];
        end else begin : g_gap
            assign pend_all[s] = 1'b0;
        end

        if (s < HW_SRCS || s >= SW_BASE) begin : g_live
            pic_src_cfg #(.NUM_OUT(NUM_OUT)) u_cfg (
                .clk     (clk),
                .rst_n   (rst_n),
                .we_i    (cfg_we[s]),
                .wdata_i (cfg_wdata),
                .pend_i  (pend_all[s]),
                .cfg_o   (cfg_all[s]),
                .route_o (route[s])
            );
        end else begin : g_none
            assign cfg_all[s] = '0;
            assign route[s]   = '0;
        end
    end

    // OR every source's request onto the output lines
    always_comb begin
        line_any = '0;
        for (int s = 0; s < NSRC; s++) line_any |= route[s];
    end

    // Register the outputs so they change only on clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= '0;
        else        irq_o <= line_any;
    end
endmodule

// File: rtl/pic_router_chk.sv
// Property checker for pic_router, attached by bind. Observes the ports
// plus the pending vector and routing words of the top module.
module pic_router_chk
    import pic_pkg::*;
#(
    parameter int HW_SRCS = 64,
    parameter int SW_SRCS = 64,
    parameter int NUM_OUT = 6,
    localparam int NSRC   = SW_BASE + SW_SRCS,
    localparam int IDX_W  = $clog2(NSRC),
    localparam int HW_W   = (HW_SRCS > 0) ? HW_SRCS : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [HW_W-1:0]      hw_irq_i,
    input logic [IDX_W+1:0]     addr_i,
    input logic                 wr_en_i,
    input logic [WORD_BITS-1:0] wr_data_i,
    input logic                 rd_en_i,
    input logic [WORD_BITS-1:0] rd_data_o,
    input logic [NUM_OUT-1:0]   irq_o,
    input logic [NSRC-1:0]      pend_all,
    input pic_cfg_t [NSRC-1:0]  cfg_all
);
    localparam int SW_WORDS = SW_SRCS / WORD_BITS;

    logic [1:0] since;
    logic       any_en;
    logic       any_routable;

    // Count cycles since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)            since <= '0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    // Summaries of the routing words
    always_comb begin
        any_en       = 1'b0;
        any_routable = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            any_en       |= cfg_all[s].en;
            any_routable |= cfg_all[s].en && (int'(cfg_all[s].sel) < NUM_OUT);
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> irq_o == '0);

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 2'd0 && !$past(rd_en_i)) |-> $stable(rd_data_o));

    for (genvar w = 0; w < SW_WORDS; w++) begin : g_word
        localparam int WI = SW_BASE / WORD_BITS + w;

        p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i[IDX_W+1:IDX_W] == 2'd2 && addr_i[IDX_W-1:0] == IDX_W'(WI))
            |=> ((pend_all[WI*WORD_BITS +: WORD_BITS] & $past(wr_data_i)) == $past(wr_data_i)));

        p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i[IDX_W+1:IDX_W] == 2'd3 && addr_i[IDX_W-1:0] == IDX_W'(WI))
            |=> ((pend_all[WI*WORD_BITS +: WORD_BITS] & $past(wr_data_i)) == '0));
    end

    if (HW_SRCS > 0) begin : g_hw
        p_hw_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (since >= 2'd2) |-> (pend_all[HW_SRCS-1:0] == $past(hw_irq_i, 2)));
    end

    p_no_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 2'd0 && !$past(any_routable)) |-> irq_o == '0);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 2'd0 && !$past(any_en)) |-> irq_o == '0);
endmodule

bind pic_router pic_router_chk #(
    .HW_SRCS (HW_SRCS),
    .SW_SRCS (SW_SRCS),
    .NUM_OUT (NUM_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_irq_i  (hw_irq_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .pend_all  (pend_all),
    .cfg_all   (cfg_all)
);

// File: tb/test_pic_router.sv
// Directed bench for pic_router with default parameters.
module test_pic_router;
    localparam int ADDR_W = 9;
    localparam logic [1:0] CFG = 2'd0, PND = 2'd1, SET = 2'd2, CLR = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [63:0]       hw_irq = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [63:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [63:0]       rd_data;
    logic [5:0]        irq;
    int checks = 0;
    int errors = 0;

    pic_router i_pic_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_irq_i  (hw_irq),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    always #2 clk = ~clk;

    function automatic logic [ADDR_W-1:0] ad(input logic [1:0] r, input int i);
        return {r, 7'(i)};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [63:0] d);
        addr = a; rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [63:0] v;
        chk("R1 irq", 64'(irq), 64'h0);
        rd(ad(CFG, 5), v);   chk("R1 cfg5", v, 64'h0);
        rd(ad(CFG, 100), v); chk("R1 cfg100", v, 64'h0);
        rd(ad(PND, 1), v);   chk("R1 soft pending", v, 64'h0);
    endtask

    task automatic t_layout;
        logic [63:0] v;
        wr(ad(CFG, 3), 64'hFFFF_FFFF_FFFF_FFFF);
        rd(ad(CFG, 3), v); chk("R2 reserved bits zero", v, 64'h0000_0000_FFFF_FF0F);
        wr(ad(CFG, 66), 64'h0000_0000_8000_0702);
        rd(ad(CFG, 66), v); chk("R2 fields", v, 64'h0000_0000_8000_0702);
        wr(ad(CFG, 66), 64'h0);
        rd(ad(CFG, 66), v); chk("R2 zero word", v, 64'h0);
    endtask

    task automatic t_read_hold;
        logic [63:0] v;
        rd(ad(CFG, 3), v); chk("R3 read value", v, 64'h0000_0000_FFFF_FF0F);
        wr(ad(CFG, 3), 64'h0);
        tick(3);
        chk("R3 held without read", rd_data, 64'h0000_0000_FFFF_FF0F);
        rd(ad(CFG, 3), v); chk("R3 new read", v, 64'h0);
    endtask

    task automatic t_set_clear;
        logic [63:0] v;
        wr(ad(SET, 1), 64'h5);
        rd(ad(PND, 1), v); chk("R4 set", v, 64'h5);
        wr(ad(SET, 1), 64'h8000_0000_0000_0002);
        rd(ad(PND, 1), v); chk("R4 zero bits keep", v, 64'h8000_0000_0000_0007);
        wr(ad(CLR, 1), 64'h1);
        rd(ad(PND, 1), v); chk("R5 clear", v, 64'h8000_0000_0000_0006);
        wr(ad(CLR, 1), 64'h0);
        rd(ad(PND, 1), v); chk("R5 zero mask", v, 64'h8000_0000_0000_0006);
        rd(ad(PND, 0), v); chk("R10 hardware word", v, 64'h0);
        wr(ad(CLR, 1), '1);
        rd(ad(PND, 1), v); chk("R5 clear all", v, 64'h0);
    endtask

    task automatic t_route;
        wr(ad(CFG, 65), 64'h8000_0702);
        wr(ad(CFG, 66), 64'h8000_0002);
        wr(ad(SET, 1), 64'h6);
        tick(1); chk("R7 line 2", 64'(irq), 64'h04);
        wr(ad(CLR, 1), 64'h2);
        tick(1); chk("R7 OR keeps line", 64'(irq), 64'h04);
        wr(ad(CLR, 1), 64'h4);
        tick(1); chk("R7 line drops", 64'(irq), 64'h00);
        wr(ad(CFG, 80), 64'h8000_0000);
        wr(ad(CFG, 81), 64'h8000_0005);
        wr(ad(SET, 1), 64'h3_0000);
        tick(1); chk("R7 two lines", 64'(irq), 64'h21);
        wr(ad(CFG, 65), 64'h0); wr(ad(CFG, 66), 64'h0);
        wr(ad(CFG, 80), 64'h0); wr(ad(CFG, 81), 64'h0);
        wr(ad(CLR, 1), '1);
        tick(1); chk("R7 idle", 64'(irq), 64'h0);
    endtask

    task automatic t_sel_range;
        wr(ad(CFG, 70), 64'h8000_0006);
        wr(ad(SET, 1), 64'h40);
        tick(1); chk("R8 selector 6", 64'(irq), 64'h0);
        wr(ad(CFG, 70), 64'h8000_000F);
        tick(1); chk("R8 selector 15", 64'(irq), 64'h0);
        wr(ad(CFG, 70), 64'h0);
        wr(ad(CLR, 1), '1);
    endtask

    task automatic t_disabled;
        logic [63:0] v;
        wr(ad(CFG, 71), 64'h1);
        wr(ad(SET, 1), 64'h80);
        tick(1); chk("R9 disabled quiet", 64'(irq), 64'h0);
        rd(ad(PND, 1), v); chk("R9 pending visible", v, 64'h80);
        wr(ad(CFG, 71), 64'h8000_0001);
        tick(1); chk("R9 enabled line 1", 64'(irq), 64'h02);
        wr(ad(CFG, 71), 64'h0);
        tick(1); chk("R9 zero word", 64'(irq), 64'h0);
        wr(ad(CLR, 1), '1);
    endtask

    task automatic t_hw;
        logic [63:0] v;
        wr(ad(CFG, 10), 64'h8000_0000);
        hw_irq[10] = 1'b1;
        tick(2); chk("R6 not yet", 64'(irq), 64'h0);
        tick(1); chk("R6 third edge", 64'(irq), 64'h01);
        rd(ad(PND, 0), v); chk("R10 hw bit 10", v, 64'h400);
        wr(ad(CLR, 0), 64'h400);
        rd(ad(PND, 0), v); chk("R6 clear ignored", v, 64'h400);
        wr(ad(SET, 0), 64'h800);
        rd(ad(PND, 0), v); chk("R6 set ignored", v, 64'h400);
        chk("R6 line held", 64'(irq), 64'h01);
        hw_irq[10] = 1'b0;
        tick(3); chk("R6 release", 64'(irq), 64'h0);
        wr(ad(CFG, 10), 64'h0);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_layout();
        t_read_hold();
        t_set_clear();
        t_route();
        t_sel_range();
        t_disabled();
        t_hw();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule